// File: doc/BRIEF.md
# Hub Status Change Interrupt Endpoint

This block is the response logic behind a hub's interrupt endpoint that tells the host which parts of the hub have changed state. It has one change source for the hub itself and one for each downstream port. Each source holds a pending bit. The bit is set by a one-cycle pulse from the status logic and is cleared only when the host issues an explicit clear request.

At every end-of-frame marker the pending bits are copied into a one-byte bitmap. An IN token for this endpoint always reads that copy and never the live bits. The block answers one cycle after the token:
- a NAK when the copy is empty;
- a NAK when the hub is not yet configured, whatever the copy holds;
- otherwise a DATA response that carries the whole byte.

The block also keeps the data toggle for the endpoint. The toggle advances when the host acknowledges a DATA response, and it returns to zero while the hub is unconfigured. Packet serialization is done elsewhere. This block only supplies the response kind, the byte and the toggle.

Top module: `hub_stat_ep`

## Requirements
- R1: Bitmap layout. Bit 0 is the hub change. Bits 1 to 4 are the changes for ports 1 to 4, in that order. Bits 5 to 7 always read 0. `chg_set_i` and `chg_clr_i` use the same bit order.
- R2: A pulse on `chg_set_i[k]` sets pending bit k, and the bit stays set until a pulse on `chg_clr_i[k]` clears it. A clear affects only its own bit. When set and clear arrive in the same cycle, set wins.
- R3: The bitmap is loaded from the pending bits only on a cycle with `eof_i` high. A change that is set in the same cycle as `eof_i`, or later, is not seen until the next end-of-frame.
- R4: When `in_tok_i` is high in cycle n, `rsp_valid_o` is high in cycle n+1 only. `rsp_valid_o` is never high without a token.
- R5: If the bitmap is all zero, the response is a NAK: `rsp_data_o`=0 and `data_o`=0.
- R6: If the hub is configured and the bitmap is non-zero, the response is DATA: `rsp_data_o`=1 and `data_o` carries the whole bitmap byte.
- R7: A change keeps being reported on every poll until it has been cleared and a later end-of-frame has resampled the pending bits.
- R8: While `configured_i` is low, every token gets a NAK, whatever changes are pending.
- R9: A clear that arrives between an end-of-frame and a token does not alter that token's answer. It takes effect at the next end-of-frame.
- R10: `toggle_o` inverts on an `ack_i` pulse that follows a DATA response, before the next token. A second ack, or an ack after a NAK, is ignored. `toggle_o` is forced to 0 while `configured_i` is low.
- R11: After reset, all pending bits, the bitmap and `toggle_o` are 0, and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_set_i | input | 5 | Change pulses, bit 0 hub, bits 1..4 ports |
| chg_clr_i | input | 5 | Host clear requests, same bit order |
| eof_i | input | 1 | End-of-frame sample marker |
| in_tok_i | input | 1 | IN token addressed to this endpoint |
| configured_i | input | 1 | Hub is configured |
| ack_i | input | 1 | Host handshake for the last DATA response |
| rsp_valid_o | output | 1 | Response available this cycle |
| rsp_data_o | output | 1 | 1 = DATA, 0 = NAK |
| data_o | output | 8 | Bitmap byte (0 on NAK) |
| toggle_o | output | 1 | Data toggle to send with DATA |

## Verification
Some properties are checked on every cycle:
- the reserved bits stay zero;
- a response appears only on the cycle after a token;
- a DATA response is never empty;
- an unconfigured hub never answers with DATA;
- the pending bits obey set and clear;
- the toggle moves only on an ack or on loss of configuration.

Only the bench scenarios can show the frame-snapshot timing. These include a change that lands on the sampling cycle, a clear that falls between sampling and the poll, repeated polls of a change that has not been cleared, and acks that arrive after a NAK or a second time.

// File: rtl/hub_stat_pkg.sv
package hub_stat_pkg;
  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned NUM_SRC   = NUM_PORTS + 1;  // bit 0 hub, then ports
  localparam int unsigned MAP_W     = 8;
  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [MAP_W-1:0]   map_t;
endpackage

// File: rtl/hub_chg_latch.sv
module hub_chg_latch #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[k] <= 1'b0;
      else if (set_i[k])  pend_q[k] <= 1'b1;  // set wins
      else if (clr_i[k])  pend_q[k] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> (pend_o == $past(pend_o)));
  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/hub_chg_snap.sv
module hub_chg_snap
  import hub_stat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t pend_i,
  input  logic     eof_i,
  output map_t     map_o
);
  map_t map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_q <= '0;
    else if (eof_i) map_q <= map_t'(pend_i);
  end

  assign map_o = map_q;

  // R3
  snap_only_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eof_i |=> $stable(map_o));
  // R1
  snap_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_o[MAP_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/hub_in_resp.sv
module hub_in_resp
  import hub_stat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  map_t map_i,
  input  logic in_tok_i,
  input  logic configured_i,
  input  logic ack_i,
  output logic rsp_valid_o,
  output logic rsp_data_o,
  output map_t data_o,
  output logic toggle_o
);
  logic rsp_valid_q, rsp_data_q, await_q, toggle_q;
  map_t data_q;
  logic send_data;

  assign send_data = configured_i && (map_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 1'b0;
      data_q      <= '0;
    end else begin
      rsp_valid_q <= in_tok_i;
      rsp_data_q  <= in_tok_i && send_data;
      data_q      <= (in_tok_i && send_data) ? map_i : '0;
    end
  end

  // await_q: a DATA response is outstanding and not yet acknowledged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      await_q  <= 1'b0;
      toggle_q <= 1'b0;
    end else if (!configured_i) begin
      await_q  <= 1'b0;
      toggle_q <= 1'b0;
    end else begin
      if (in_tok_i)              await_q <= send_data;
      else if (ack_i)            await_q <= 1'b0;
      if (ack_i && await_q && !in_tok_i) toggle_q <= ~toggle_q;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign data_o      = data_q;
  assign toggle_o    = toggle_q;

  // R4
  rsp_after_tok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(in_tok_i));
  // R6
  data_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_data_o |-> (rsp_valid_o && data_o != '0));
  // R8
  nak_unconf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && !configured_i) |=> !rsp_data_o);
  // R10
  toggle_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_o != $past(toggle_o)) |-> ($past(ack_i) || !$past(configured_i)));
  // R5
  nak_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_data_o) |-> (data_o == '0));
endmodule

// File: rtl/hub_stat_ep.sv
module hub_stat_ep
  import hub_stat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] chg_set_i,
  input  logic [NUM_SRC-1:0] chg_clr_i,
  input  logic               eof_i,
  input  logic               in_tok_i,
  input  logic               configured_i,
  input  logic               ack_i,
  output logic               rsp_valid_o,
  output logic               rsp_data_o,
  output logic [MAP_W-1:0]   data_o,
  output logic               toggle_o
);
  src_vec_t pend;
  map_t     map;

  hub_chg_latch #(.N(NUM_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg_set_i),
    .clr_i  (chg_clr_i),
    .pend_o (pend)
  );

  hub_chg_snap u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .eof_i  (eof_i),
    .map_o  (map)
  );

  hub_in_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .map_i        (map),
    .in_tok_i     (in_tok_i),
    .configured_i (configured_i),
    .ack_i        (ack_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o),
    .data_o       (data_o),
    .toggle_o     (toggle_o)
  );

  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[MAP_W-1:NUM_SRC] == '0);
endmodule

// File: tb/hub_stat_ep_tb.sv
module hub_stat_ep_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] set_v = '0, clr_v = '0;
  logic eof = 1'b0, tok = 1'b0, cfg = 1'b0, ack = 1'b0;
  logic rsp_valid, rsp_data, toggle;
  logic [7:0] data;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  hub_stat_ep u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chg_set_i(set_v), .chg_clr_i(clr_v),
    .eof_i(eof), .in_tok_i(tok), .configured_i(cfg), .ack_i(ack),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .data_o(data),
    .toggle_o(toggle)
  );

  // {set, clr, do_eof, cfg, exp_data, exp_byte}
  typedef struct packed {
    logic [4:0] set;
    logic [4:0] clr;
    logic       do_eof;
    logic       cfg;
    logic       exp_data;
    logic [7:0] exp_byte;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 5'h00, 1'b1, 1'b1, 1'b0, 8'h00},  // R5 empty
    '{5'h02, 5'h00, 1'b0, 1'b1, 1'b0, 8'h00},  // R3 not yet sampled
    '{5'h00, 5'h00, 1'b1, 1'b1, 1'b1, 8'h02},  // R6 port1
    '{5'h00, 5'h00, 1'b0, 1'b1, 1'b1, 8'h02},  // R7 repeat poll
    '{5'h01, 5'h00, 1'b1, 1'b1, 1'b1, 8'h03},  // R1 hub bit0
    '{5'h00, 5'h02, 1'b0, 1'b1, 1'b1, 8'h03},  // R9 clear not yet seen
    '{5'h00, 5'h00, 1'b1, 1'b1, 1'b1, 8'h01},  // R9 clear after eof
    '{5'h10, 5'h00, 1'b1, 1'b0, 1'b0, 8'h00},  // R8 unconfigured
    '{5'h00, 5'h00, 1'b0, 1'b1, 1'b1, 8'h11},  // R8 configured again
    '{5'h00, 5'h11, 1'b1, 1'b1, 1'b0, 8'h00},  // R2 clears
    '{5'h1E, 5'h00, 1'b1, 1'b1, 1'b1, 8'h1E},  // R1 all ports
    '{5'h00, 5'h1E, 1'b1, 1'b1, 1'b0, 8'h00}   // R7 gone after clear+eof
  };

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [4:0] s, input logic [4:0] c, input logic e);
    step(); set_v = s; clr_v = c; eof = e;
    step(); set_v = '0; clr_v = '0; eof = 1'b0;
  endtask

  // token at negedge, response sampled at following negedge
  task automatic poll(input string req, input logic exp_d, input logic [7:0] exp_b);
    step(); tok = 1'b1;
    step(); tok = 1'b0;
    chk(rsp_valid && rsp_data == exp_d && data == exp_b, req,
        {6'd0, rsp_valid, rsp_data, data}, {7'd1, exp_d, exp_b});
  endtask

  task automatic do_ack;
    step(); ack = 1'b1;
    step(); ack = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk(!rsp_valid && !rsp_data && data == 0 && !toggle, "R11",
        {rsp_valid, rsp_data, toggle, 5'd0, data}, 16'h0);
    cfg = 1'b1;
    step();
    poll("R11 empty after reset", 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(); cfg = VECS[i].cfg;
      if (VECS[i].set != 0 || VECS[i].clr != 0) pulse(VECS[i].set, VECS[i].clr, 1'b0);
      if (VECS[i].do_eof) pulse('0, '0, 1'b1);
      poll($sformatf("vec%0d R5/R6", i), VECS[i].exp_data, VECS[i].exp_byte);
    end

    // R4 response lasts one cycle
    step();
    chk(!rsp_valid, "R4", {15'd0, rsp_valid}, 16'h0);

    // R10 toggle flips on ack after DATA
    pulse(5'h04, '0, 1'b0);
    pulse('0, '0, 1'b1);
    poll("R10 data", 1'b1, 8'h04);
    chk(!toggle, "R10 before ack", {15'd0, toggle}, 16'h0);
    do_ack();
    chk(toggle, "R10 after ack", {15'd0, toggle}, 16'h1);
    do_ack();
    chk(toggle, "R10 second ack ignored", {15'd0, toggle}, 16'h1);
    pulse('0, 5'h04, 1'b0);
    pulse('0, '0, 1'b1);
    poll("R10 nak", 1'b0, 8'h00);
    do_ack();
    chk(toggle, "R10 ack after nak ignored", {15'd0, toggle}, 16'h1);
    step(); cfg = 1'b0;
    step(); cfg = 1'b1;
    chk(!toggle, "R10 unconfig resets", {15'd0, toggle}, 16'h0);

    // R3 set on the eof cycle is not captured
    pulse(5'h08, '0, 1'b1);
    poll("R3 same-cycle set", 1'b0, 8'h00);
    pulse('0, '0, 1'b1);
    poll("R3 next eof", 1'b1, 8'h08);

    // R2 set wins over clear
    pulse(5'h08, 5'h08, 1'b0);
    pulse('0, '0, 1'b1);
    poll("R2 set wins", 1'b1, 8'h08);
    pulse('0, 5'h08, 1'b0);
    pulse('0, '0, 1'b1);
    poll("R2 cleared", 1'b0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule